// File: doc/BRIEF.md
# Dual Timer Control and Event Logic

This block holds one 32-bit control register that governs two independent timer halves, A and B. Each half owns a free-running down-counter that reloads from a fixed value, a polarity stage for its raw PWM level, an edge detector that raises a one-cycle interrupt, and a one-cycle ADC trigger strobe issued when its counter passes through zero.

Software writes the whole control word through a plain write strobe and reads it back combinationally. A debug-halt input can freeze either counter, controlled by a per-half stall bit, and an RTC-mode input freezes counting during a halt unless a shared override bit keeps the counters running. Selecting output inversion for a half also flips which raw edge its event detector answers to, because detection works on the level after the polarity stage. All pins are plain control and status signals; there is no streaming interface and so no back-pressure.

Top module: `dual_timer_ctl`

## Requirements
- R1: The control word resets to zero. Implemented fields are: half A enable bit 0, stall bit 1, event mode bits 3:2, run-during-halt override bit 4 (shared), trigger enable bit 5, invert bit 6; half B uses bits 8, 9, 11:10, 13, 14 for enable, stall, event mode, trigger enable and invert. A write stores the word with all other bits forced to zero, so the read value after writing all ones is 0x00006F7F.
- R2: A half whose enable bit is clear holds its count; once enabled it decrements by one each cycle from its present value. Counters reset to LOAD_VAL.
- R3: A running counter at zero reloads LOAD_VAL on the next cycle instead of decrementing.
- R4: With debug halt high and the half's stall bit set, the count holds; with halt low the stall bit has no effect; with the stall bit clear the count keeps running during halt.
- R5: With RTC mode high, debug halt high and the override bit clear, both counters hold even when their stall bits are clear.
- R6: With the override bit (bit 4) set, neither counter holds during debug halt, whatever its stall bit or RTC mode.
- R7: The ADC trigger of a half pulses high for one cycle, in the cycle the counter shows LOAD_VAL after a reload from zero, only if that half's trigger enable bit is set; when clear, no trigger appears.
- R8: Each PWM output equals the raw PWM level when its invert bit is 0 and its complement when the invert bit is 1, without delay.
- R9: Event mode 0 fires on a rising edge of the PWM output, 1 on a falling edge, 3 on either; the interrupt is a one-cycle pulse in the cycle after the edge is sampled. With inversion on, mode 0 therefore fires on a falling raw edge.
- R10: Event mode 2 never raises an interrupt, and a half with its enable bit clear raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word |
| dbg_halt | input | 1 | Processor halted by the debugger |
| rtc_mode | input | 1 | Timers operate in RTC mode |
| pwm_raw | input | 2 | Raw PWM level, bit 0 half A, bit 1 half B |
| pwm_out | output | 2 | PWM level after polarity selection |
| evt_irq | output | 2 | One-cycle edge-event interrupt per half |
| adc_trig | output | 2 | One-cycle ADC trigger strobe per half |
| count_a | output | CNT_W | Half A counter value |
| count_b | output | CNT_W | Half B counter value |

## Verification
The bench builds the block with CNT_W set to 8 and LOAD_VAL set to 5, so each counter wraps every six running cycles. That short period puts the reload, the trigger strobe and its gating within a few cycles of any test start, and lets frozen and running counts be told apart after only two or three cycles. Every edge mode is driven with and without inversion on half A, with spot checks on half B for counting, halt override and polarity.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_OFF  = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      inv;
    logic      trig_en;
    edge_sel_e edge_sel;
    logic      stall;
    logic      en;
  } half_cfg_t;

  localparam int NUM_HALVES  = 2;
  localparam int HALF_STRIDE = 8;
  // Implemented bits of the control word, bits 0-6 and 8-11,13,14.
  localparam logic [31:0] CTL_MASK = 32'h0000_6F7F;

endpackage

// File: rtl/dtc_regs.sv
module dtc_regs
  import dtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output half_cfg_t   cfg [NUM_HALVES],
  output logic        run_in_halt
);

  logic [31:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (reg_wr) begin
      ctl_q <= reg_wdata & CTL_MASK;
    end
  end

  assign reg_rdata   = ctl_q;
  assign run_in_halt = ctl_q[4];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_cfg
    localparam int B = h * HALF_STRIDE;
    assign cfg[h].en       = ctl_q[B + 0];
    assign cfg[h].stall    = ctl_q[B + 1];
    assign cfg[h].edge_sel = edge_sel_e'(ctl_q[B + 3 : B + 2]);
    assign cfg[h].trig_en  = ctl_q[B + 5];
    assign cfg[h].inv      = ctl_q[B + 6];
  end

  // R1: a write lands with reserved positions cleared
  a_r1_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == ($past(reg_wdata) & CTL_MASK)));

endmodule

// File: rtl/dtc_half.sv
module dtc_half
  import dtc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOAD_VAL = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  half_cfg_t        cfg,
  input  logic             run_in_halt,
  input  logic             dbg_halt,
  input  logic             rtc_mode,
  input  logic             pwm_raw,
  output logic             pwm_out,
  output logic             evt_irq,
  output logic             adc_trig,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOAD_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_q, irq_q, trig_q;
  logic             freeze, run, at_zero, rise, fall, hit;

  assign freeze  = dbg_halt && !run_in_halt && (cfg.stall || rtc_mode);
  assign run     = cfg.en && !freeze;
  assign at_zero = (cnt_q == '0);
  assign pwm_out = pwm_raw ^ cfg.inv;
  assign rise    = pwm_out && !prev_q;
  assign fall    = !pwm_out && prev_q;

  always_comb begin
    unique case (cfg.edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise || fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      prev_q <= pwm_out;
      irq_q  <= cfg.en && hit;
      trig_q <= run && at_zero && cfg.trig_en;
      if (run) begin
        cnt_q <= at_zero ? RELOAD : cnt_q - 1'b1;
      end
    end
  end

  assign evt_irq  = irq_q;
  assign adc_trig = trig_q;
  assign count    = cnt_q;

  // R2: a disabled half keeps its count
  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> $stable(cnt_q));

  // R4: debug halt with stall selected freezes the count
  a_r4_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && cfg.stall && !run_in_halt) |=> $stable(cnt_q));

  // R3: a running count at zero comes back as the reload value
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_zero) |=> (cnt_q == RELOAD));

  // R7: a trigger only accompanies a freshly reloaded count
  a_r7_trig_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> (cnt_q == RELOAD));

  // R10: the reserved mode raises nothing
  a_r10_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edge_sel == EDGE_OFF) |=> !irq_q);

endmodule

// File: rtl/dual_timer_ctl.sv
module dual_timer_ctl
  import dtc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOAD_VAL = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dbg_halt,
  input  logic             rtc_mode,
  input  logic [1:0]       pwm_raw,
  output logic [1:0]       pwm_out,
  output logic [1:0]       evt_irq,
  output logic [1:0]       adc_trig,
  output logic [CNT_W-1:0] count_a,
  output logic [CNT_W-1:0] count_b
);

  half_cfg_t        cfg [NUM_HALVES];
  logic             run_in_halt;
  logic [CNT_W-1:0] cnt [NUM_HALVES];

  dtc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cfg         (cfg),
    .run_in_halt (run_in_halt)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dtc_half #(
      .CNT_W    (CNT_W),
      .LOAD_VAL (LOAD_VAL)
    ) u_half (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg[h]),
      .run_in_halt (run_in_halt),
      .dbg_halt    (dbg_halt),
      .rtc_mode    (rtc_mode),
      .pwm_raw     (pwm_raw[h]),
      .pwm_out     (pwm_out[h]),
      .evt_irq     (evt_irq[h]),
      .adc_trig    (adc_trig[h]),
      .count       (cnt[h])
    );
  end

  assign count_a = cnt[0];
  assign count_b = cnt[1];

endmodule

// File: tb/dual_timer_ctl_tb.sv
module dual_timer_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int LOAD_VAL   = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic             dbg_halt, rtc_mode;
  logic [1:0]       pwm_raw, pwm_out, evt_irq, adc_trig;
  logic [CNT_W-1:0] count_a, count_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_timer_ctl #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .rtc_mode(rtc_mode),
    .pwm_raw(pwm_raw), .pwm_out(pwm_out), .evt_irq(evt_irq),
    .adc_trig(adc_trig), .count_a(count_a), .count_b(count_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  function automatic int after(input int c, input int k);
    int v = c - k;
    while (v < 0) v += LOAD_VAL + 1;
    return v;
  endfunction

  task automatic t_reset();
    check("R1 reset word", reg_rdata, 32'h0);
    check("R2 reset count A", 32'(count_a), LOAD_VAL);
    check("R2 reset count B", 32'(count_b), LOAD_VAL);
    check("R7 reset trig", 32'(adc_trig), 0);
    step(3);
    check("R2 disabled A holds", 32'(count_a), LOAD_VAL);
  endtask

  task automatic t_regmap();
    wr(32'hFFFF_FFFF);
    check("R1 masked readback", reg_rdata, 32'h0000_6F7F);
    wr(32'h0);
    check("R1 cleared", reg_rdata, 32'h0);
    step(3);
  endtask

  task automatic t_count();
    int c0, b0;
    wr(32'h1);
    c0 = count_a; b0 = count_b;
    step(3);
    check("R2 A counts down", 32'(count_a), after(c0, 3));
    check("R2 B disabled holds", 32'(count_b), b0);
    wr(32'h100);
    b0 = count_b; c0 = count_a;
    step(2);
    check("R2 B counts down", 32'(count_b), after(b0, 2));
    check("R2 A disabled holds", 32'(count_a), c0);
    wr(32'h0);
  endtask

  task automatic t_wrap_trig();
    wr(32'h21);
    for (int i = 0; i < 10 && count_a != 0; i++) step(1);
    step(1);
    check("R3 reload value", 32'(count_a), LOAD_VAL);
    check("R7 trig pulse", 32'(adc_trig[0]), 1);
    step(1);
    check("R7 trig one cycle", 32'(adc_trig[0]), 0);
    wr(32'h1);
    for (int i = 0; i < 10 && count_a != 0; i++) step(1);
    step(1);
    check("R3 reload no trig", 32'(count_a), LOAD_VAL);
    check("R7 gated trig", 32'(adc_trig[0]), 0);
    wr(32'h0);
  endtask

  task automatic t_stall();
    int c0;
    wr(32'h3);
    dbg_halt = 1'b1;
    c0 = count_a;
    step(3);
    check("R4 halt+stall freezes", 32'(count_a), c0);
    dbg_halt = 1'b0;
    c0 = count_a;
    step(2);
    check("R4 stall ignored w/o halt", 32'(count_a), after(c0, 2));
    wr(32'h1);
    dbg_halt = 1'b1;
    c0 = count_a;
    step(2);
    check("R4 no stall runs in halt", 32'(count_a), after(c0, 2));
    dbg_halt = 1'b0;
    wr(32'h0);
  endtask

  task automatic t_rtc();
    int c0;
    dbg_halt = 1'b1;
    rtc_mode = 1'b1;
    wr(32'h1);
    c0 = count_a;
    step(3);
    check("R5 rtc halt freezes", 32'(count_a), c0);
    wr(32'h13);
    c0 = count_a;
    step(2);
    check("R6 override runs A", 32'(count_a), after(c0, 2));
    rtc_mode = 1'b0;
    wr(32'h310);
    c0 = count_b;
    step(2);
    check("R6 override runs B", 32'(count_b), after(c0, 2));
    dbg_halt = 1'b0;
    wr(32'h0);
  endtask

  task automatic t_pwm();
    wr(32'h4040);
    pwm_raw = 2'b01;
    #1;
    check("R8 inverted outputs", 32'(pwm_out), 2'b10);
    wr(32'h0040);
    #1;
    check("R8 A inverted B plain", 32'(pwm_out), 2'b00);
    wr(32'h0);
    pwm_raw = 2'b00;
    step(3);
  endtask

  task automatic t_edge(input string req, input int h, input logic [31:0] ctl,
                        input logic from, input logic to, input logic exp);
    pwm_raw[h] = from;
    wr(ctl);
    step(3);
    pwm_raw[h] = to;
    step(1);
    check(req, 32'(evt_irq[h]), 32'(exp));
    step(1);
    check({req, " pulse ends"}, 32'(evt_irq[h]), 0);
    wr(32'h0);
    pwm_raw = 2'b00;
    step(3);
  endtask

  initial begin
    int c_dummy;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    dbg_halt = 1'b0; rtc_mode = 1'b0; pwm_raw = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_count();
    t_wrap_trig();
    t_stall();
    t_rtc();
    t_pwm();
    t_edge("R9 rise mode rising",        0, 32'h01, 1'b0, 1'b1, 1'b1);
    t_edge("R9 rise mode falling",       0, 32'h01, 1'b1, 1'b0, 1'b0);
    t_edge("R9 rise inverted falling",   0, 32'h41, 1'b1, 1'b0, 1'b1);
    t_edge("R9 rise inverted rising",    0, 32'h41, 1'b0, 1'b1, 1'b0);
    t_edge("R9 fall mode falling",       0, 32'h05, 1'b1, 1'b0, 1'b1);
    t_edge("R9 both mode rising",        0, 32'h0D, 1'b0, 1'b1, 1'b1);
    t_edge("R9 both mode falling",       0, 32'h0D, 1'b1, 1'b0, 1'b1);
    t_edge("R10 reserved mode",          0, 32'h09, 1'b0, 1'b1, 1'b0);
    t_edge("R10 disabled no irq",        0, 32'h00, 1'b0, 1'b1, 1'b0);
    t_edge("R9 B fall mode falling",     1, 32'h500, 1'b1, 1'b0, 1'b1);
    c_dummy = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule